// File: doc/BRIEF.md
# Speculative Store Write Buffer

This block sits beside the data cache of one core in a multi-core chip that runs threads speculatively. Every store the core makes while its thread is speculative goes to the local L1 and, in the same cycle, into this buffer. The buffer keeps those stores away from the shared second-level cache until the thread is allowed to commit. Stores are gathered into 32-byte line entries. A per-byte valid mask records which bytes the thread has written. A second store to a line that is already held merges into the existing entry instead of taking a new one.

When the core becomes the non-speculative head thread, the buffer drains its entries to the L2 write port, oldest first, one line per grant. Each drained line carries its byte mask so that only the written bytes change permanent state. When the buffer is empty and the core is head, it raises a done flag so that headship can move to the next thread. Threads therefore commit in their sequential order. If the thread suffers a dependence violation, a discard pulse throws away every entry in one cycle. A speculative core whose buffer is full stalls on a store that would need a new entry.

The control is a three-state machine:
- `ST_SPEC`: collecting stores; no drain.
- `ST_DRAIN`: head, with entries to write; requests the L2 port.
- `ST_DONE`: head, buffer empty; signals done.

Its transitions are:
- `ST_SPEC` goes to `ST_DRAIN` when head arrives and entries remain, or to `ST_DONE` when head arrives and the buffer is empty.
- `ST_DRAIN` goes to `ST_DONE` when the last entry retires and no store allocates in that cycle.
- `ST_DONE` goes back to `ST_DRAIN` when the head core stores to a new line.
- `ST_DRAIN` and `ST_DONE` go to `ST_SPEC` when headship is lost or a discard arrives.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `drn_req`, `drn_done` and `st_stall` are low.
- R2: A store to a line not held takes a new entry. Its mask has bit `word*8+b` set exactly for each set strobe bit `b` of word `word`, and that mask byte carries data bits `[8b+7:8b]` of the store. All other mask bits are zero.
- R3: A store to a line already held merges into that entry. The strobed bytes are overwritten and their mask bits are ORed in. No second entry for the line is created.
- R4: `st_stall` is combinational. It is high only when a store misses, the buffer holds DEPTH (8) entries and no entry retires in that cycle. A stalled store is not taken. A store that hits a full buffer merges without stall.
- R5: While the core is not head, `drn_req` stays low whatever the buffer holds.
- R6: One cycle after head is seen with entries held, `drn_req` rises. Entries are presented on `drn_line`/`drn_data`/`drn_mask` in allocation order, and each `drn_grant` retires one of them.
- R7: The cycle after the last entry retires while head, `drn_done` is high and `drn_req` is low. `drn_done` falls the cycle after head is removed.
- R8: A `violate` pulse empties the buffer in that cycle, and a store in the next cycle is taken. If the core later becomes head with no new stores, it raises `drn_done` without any request.
- R9: While head, a store that misses a full buffer is taken in the cycle a grant retires the oldest entry. It drains after all older entries.
- R10: A store whose line matches the entry retiring in that same cycle does not merge into it. It takes a new entry holding only its own bytes, which drains later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_head | input | 1 | Core is the non-speculative head thread |
| violate | input | 1 | Discard all buffered stores |
| st_valid | input | 1 | Store presented this cycle |
| st_line | input | 27 | Line address of the store |
| st_word | input | 2 | 8-byte word within the line |
| st_data | input | 64 | Store data, byte b at bits 8b+7:8b |
| st_strb | input | 8 | Byte strobes of the word |
| st_stall | output | 1 | Store not taken; hold it and the core |
| drn_req | output | 1 | Request to write the oldest entry to L2 |
| drn_grant | input | 1 | L2 port accepts the presented line |
| drn_line | output | 27 | Line address of the oldest entry |
| drn_data | output | 256 | Line data of the oldest entry |
| drn_mask | output | 32 | Byte-valid mask of the oldest entry |
| drn_done | output | 1 | Head with an empty buffer |

## Verification
The main function is exercised with several store patterns. Partial-word stores that later overlap the same word separate a correct byte merge from a whole-word overwrite, and a store to a further word of the same line shows that no second entry is made. Filling the buffer with distinct lines and then sending one more miss and one hit separates the stall-on-allocate rule from a stall-on-full rule. On the head side, a full-buffer miss during a grant and a store to the very line being retired show whether the retiring slot is reused correctly and whether drain order is kept. A discard followed by headship shows that no stale entry leaks into the L2.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [1:0] {
        ST_SPEC  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_DONE  = 2'd2
    } ssb_state_e;
endpackage

// File: rtl/ssb_match.sv
// Line-address lookup across all entries, excluding the one retiring now.
module ssb_match #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 27,
    parameter int IDX_W  = 3
) (
    input  logic [DEPTH-1:0][LINE_W-1:0] tags,
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0]             skip,
    input  logic [LINE_W-1:0]            line,
    output logic [DEPTH-1:0]             hit_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = vld[i] && !skip[i] && (tags[i] == line);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ssb_merge.sv
// Places the strobed bytes of one word into a line image and its mask.
module ssb_merge #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8,
    parameter int WSEL_W     = 2
) (
    input  logic [LINE_BYTES*8-1:0] old_data,
    input  logic [LINE_BYTES-1:0]   old_mask,
    input  logic [WSEL_W-1:0]       word_sel,
    input  logic [WORD_BYTES*8-1:0] wdata,
    input  logic [WORD_BYTES-1:0]   wstrb,
    output logic [LINE_BYTES*8-1:0] new_data,
    output logic [LINE_BYTES-1:0]   new_mask
);
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        localparam int LANE = b % WORD_BYTES;
        logic take;
        assign take = (word_sel == WSEL_W'(b / WORD_BYTES)) && wstrb[LANE];
        assign new_data[b*8 +: 8] = take ? wdata[LANE*8 +: 8] : old_data[b*8 +: 8];
        assign new_mask[b]        = take | old_mask[b];
    end
endmodule

// File: rtl/ssb_ctrl.sv
// Headship / drain state machine.
module ssb_ctrl
    import ssb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_head,
    input  logic violate,
    input  logic next_empty,
    output logic drn_req,
    output logic drn_done
);
    ssb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SPEC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SPEC: begin
                if (!violate && is_head) state_d = next_empty ? ST_DONE : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (violate || !is_head) state_d = ST_SPEC;
                else if (next_empty)     state_d = ST_DONE;
            end
            ST_DONE: begin
                if (violate || !is_head) state_d = ST_SPEC;
                else if (!next_empty)    state_d = ST_DRAIN;
            end
            default: state_d = ST_SPEC;
        endcase
    end

    always_comb begin
        drn_req  = 1'b0;
        drn_done = 1'b0;
        unique case (state_q)
            ST_SPEC:  ;
            ST_DRAIN: drn_req  = 1'b1;
            ST_DONE:  drn_done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer #(
    parameter int DEPTH      = 8,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8,
    parameter int ADDR_W     = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES),
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int WORD_BITS = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  is_head,
    input  logic                  violate,
    input  logic                  st_valid,
    input  logic [LINE_W-1:0]     st_line,
    input  logic [WSEL_W-1:0]     st_word,
    input  logic [WORD_BITS-1:0]  st_data,
    input  logic [WORD_BYTES-1:0] st_strb,
    output logic                  st_stall,
    output logic                  drn_req,
    input  logic                  drn_grant,
    output logic [LINE_W-1:0]     drn_line,
    output logic [LINE_BITS-1:0]  drn_data,
    output logic [LINE_BYTES-1:0] drn_mask,
    output logic                  drn_done
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][LINE_W-1:0]     tag_q;
    logic [DEPTH-1:0][LINE_BITS-1:0]  data_q;
    logic [DEPTH-1:0][LINE_BYTES-1:0] mask_q;
    logic [DEPTH-1:0]                 vld_q;
    logic [IDX_W-1:0]                 rd_q, wr_q;
    logic [CNT_W-1:0]                 cnt_q, cnt_d;

    logic                  retire, full_eff, accept, alloc, merge_w;
    logic [DEPTH-1:0]      skip_vec, hit_vec;
    logic                  hit;
    logic [IDX_W-1:0]      hit_idx;
    logic [LINE_BITS-1:0]  base_data, upd_data;
    logic [LINE_BYTES-1:0] base_mask, upd_mask;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign retire   = drn_req && drn_grant && !violate;
    assign skip_vec = retire ? (DEPTH'(1) << rd_q) : '0;

    ssb_match #(.DEPTH(DEPTH), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_match (
        .tags(tag_q), .vld(vld_q), .skip(skip_vec), .line(st_line),
        .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
    );

    assign full_eff = (cnt_q == CNT_W'(DEPTH)) && !retire;
    assign st_stall = st_valid && !hit && full_eff;
    assign accept   = st_valid && !st_stall && !violate;
    assign alloc    = accept && !hit;
    assign merge_w  = accept && hit;

    assign base_data = hit ? data_q[hit_idx] : '0;
    assign base_mask = hit ? mask_q[hit_idx] : '0;

    ssb_merge #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .WSEL_W(WSEL_W)) u_merge (
        .old_data(base_data), .old_mask(base_mask), .word_sel(st_word),
        .wdata(st_data), .wstrb(st_strb),
        .new_data(upd_data), .new_mask(upd_mask)
    );

    assign cnt_d = violate ? '0 : (cnt_q + CNT_W'(alloc) - CNT_W'(retire));

    always_ff @(posedge clk) begin
        if (!rst_n || violate) begin
            vld_q  <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
            tag_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (retire) begin
                vld_q[rd_q] <= 1'b0;
                rd_q        <= wrap_inc(rd_q);
            end
            if (alloc) begin
                vld_q[wr_q]  <= 1'b1;
                tag_q[wr_q]  <= st_line;
                mask_q[wr_q] <= upd_mask;
                wr_q         <= wrap_inc(wr_q);
            end else if (merge_w) begin
                mask_q[hit_idx] <= upd_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc)        data_q[wr_q]    <= upd_data;
        else if (merge_w) data_q[hit_idx] <= upd_data;
    end

    ssb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .is_head(is_head), .violate(violate),
        .next_empty(cnt_d == '0), .drn_req(drn_req), .drn_done(drn_done)
    );

    assign drn_line = tag_q[rd_q];
    assign drn_data = data_q[rd_q];
    assign drn_mask = mask_q[rd_q];
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             is_head,
    input logic             violate,
    input logic             st_stall,
    input logic             drn_req,
    input logic             drn_grant,
    input logic             drn_done,
    input logic             alloc,
    input logic [CNT_W-1:0] cnt,
    input logic [DEPTH-1:0] hit_vec
);
    AST_REQ_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        drn_req |-> $past(is_head)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R4

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (cnt == CNT_W'(DEPTH))); // R4

    AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        violate |=> (cnt == '0)); // R8

    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        drn_done |-> (cnt == '0) && !drn_req); // R7

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3

    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_req && drn_grant && !violate && !alloc) |=> (cnt == $past(cnt) - CNT_W'(1))); // R6
endmodule

bind spec_store_buffer ssb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .is_head(is_head), .violate(violate),
    .st_stall(st_stall), .drn_req(drn_req), .drn_grant(drn_grant),
    .drn_done(drn_done), .alloc(alloc), .cnt(cnt_q), .hit_vec(hit_vec)
);

// File: tb/tb_spec_store_buffer.sv
`timescale 1ns/1ps
module tb_spec_store_buffer;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n, is_head, violate, st_valid, drn_grant;
    logic [26:0]  st_line;
    logic [1:0]   st_word;
    logic [63:0]  st_data;
    logic [7:0]   st_strb;
    logic         st_stall, drn_req, drn_done;
    logic [26:0]  drn_line;
    logic [255:0] drn_data;
    logic [31:0]  drn_mask;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spec_store_buffer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .is_head(is_head), .violate(violate),
        .st_valid(st_valid), .st_line(st_line), .st_word(st_word),
        .st_data(st_data), .st_strb(st_strb), .st_stall(st_stall),
        .drn_req(drn_req), .drn_grant(drn_grant), .drn_line(drn_line),
        .drn_data(drn_data), .drn_mask(drn_mask), .drn_done(drn_done)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [26:0] line, input logic [1:0] word,
                            input logic [63:0] data, input logic [7:0] strb,
                            input logic exp_stall, input string req);
        @(negedge clk);
        st_valid = 1'b1; st_line = line; st_word = word; st_data = data; st_strb = strb;
        #1 chk(req, 256'(st_stall), 256'(exp_stall));
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic pulse_violate();
        @(negedge clk); violate = 1'b1;
        @(negedge clk); violate = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req", 256'(drn_req), 256'(0));
        chk("R1 done", 256'(drn_done), 256'(0));
        chk("R1 stall", 256'(st_stall), 256'(0));
    endtask

    task automatic t_merge_and_drain();
        logic [255:0] exp_d;
        do_store(27'h123, 2'd1, 64'h1111_2222_3333_4444, 8'h0F, 1'b0, "R2 alloc");
        do_store(27'h123, 2'd1, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0, 1'b0, "R3 merge");
        do_store(27'h123, 2'd3, 64'h0000_0000_0000_0055, 8'h01, 1'b0, "R3 merge");
        do_store(27'h456, 2'd0, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0, "R2 alloc");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 no req while speculative", 256'(drn_req), 256'(0));
        end
        is_head = 1'b1;
        @(negedge clk);
        exp_d = '0;
        exp_d[127:64]  = 64'hAAAA_BBBB_3333_4444;
        exp_d[199:192] = 8'h55;
        chk("R6 req", 256'(drn_req), 256'(1));
        chk("R6 oldest line", 256'(drn_line), 256'(27'h123));
        chk("R3 merged mask", 256'(drn_mask), 256'(32'h0100_FF00));
        chk("R3 merged data", drn_data, exp_d);
        drn_grant = 1'b1;
        @(negedge clk);
        chk("R6 second line", 256'(drn_line), 256'(27'h456));
        chk("R2 mask", 256'(drn_mask), 256'(32'h0000_00FF));
        chk("R2 data", drn_data, {192'b0, 64'h0123_4567_89AB_CDEF});
        @(negedge clk);
        drn_grant = 1'b0;
        chk("R7 done", 256'(drn_done), 256'(1));
        chk("R7 req low", 256'(drn_req), 256'(0));
        is_head = 1'b0;
        @(negedge clk);
        chk("R7 done falls", 256'(drn_done), 256'(0));
    endtask

    task automatic t_full_and_discard();
        for (int i = 0; i < DEPTH; i++)
            do_store(27'h200 + 27'(i), 2'd0, 64'(i), 8'h01, 1'b0, "R4 fill");
        do_store(27'h300, 2'd0, 64'h9, 8'h01, 1'b1, "R4 stall on full miss");
        do_store(27'h200, 2'd2, 64'h9, 8'h01, 1'b0, "R4 hit full no stall");
        pulse_violate();
        do_store(27'h301, 2'd0, 64'h5A, 8'h01, 1'b0, "R8 store after discard");
        @(negedge clk); is_head = 1'b1;
        @(negedge clk);
        chk("R8 only new line", 256'(drn_line), 256'(27'h301));
        chk("R8 req", 256'(drn_req), 256'(1));
        drn_grant = 1'b1;
        @(negedge clk);
        drn_grant = 1'b0;
        chk("R8 done after one", 256'(drn_done), 256'(1));
        is_head = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_discard_then_head();
        for (int i = 0; i < 3; i++)
            do_store(27'h600 + 27'(i), 2'd0, 64'h1, 8'h01, 1'b0, "R8 fill");
        pulse_violate();
        is_head = 1'b1;
        @(negedge clk);
        chk("R8 no req after discard", 256'(drn_req), 256'(0));
        chk("R8 done after discard", 256'(drn_done), 256'(1));
        is_head = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_head_full_miss();
        for (int i = 0; i < DEPTH; i++)
            do_store(27'h400 + 27'(i), 2'd0, 64'(i), 8'h01, 1'b0, "R9 fill");
        @(negedge clk); is_head = 1'b1;
        @(negedge clk);
        chk("R9 first line", 256'(drn_line), 256'(27'h400));
        st_valid = 1'b1; st_line = 27'h4FF; st_word = 2'd0; st_data = 64'h77; st_strb = 8'h01;
        drn_grant = 1'b1;
        #1 chk("R9 head full miss taken on grant", 256'(st_stall), 256'(0));
        @(posedge clk); #1 st_valid = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            @(negedge clk);
            chk("R9 drain order", 256'(drn_line), 256'((k < DEPTH) ? 27'h400 + 27'(k) : 27'h4FF));
        end
        chk("R9 new mask", 256'(drn_mask), 256'(32'h1));
        chk("R9 new data", drn_data, 256'(64'h77));
        @(negedge clk);
        drn_grant = 1'b0;
        chk("R9 done", 256'(drn_done), 256'(1));
        is_head = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_store_to_retiring();
        do_store(27'h500, 2'd0, 64'h11, 8'h01, 1'b0, "R10 fill");
        do_store(27'h501, 2'd0, 64'h22, 8'h01, 1'b0, "R10 fill");
        @(negedge clk); is_head = 1'b1;
        @(negedge clk);
        chk("R10 oldest", 256'(drn_line), 256'(27'h500));
        st_valid = 1'b1; st_line = 27'h500; st_word = 2'd1; st_data = 64'h2233; st_strb = 8'h03;
        drn_grant = 1'b1;
        @(posedge clk); #1 st_valid = 1'b0;
        @(negedge clk);
        chk("R10 next is 501", 256'(drn_line), 256'(27'h501));
        @(negedge clk);
        chk("R10 reissued line", 256'(drn_line), 256'(27'h500));
        chk("R10 own bytes only", 256'(drn_mask), 256'(32'h0000_0300));
        chk("R10 data", drn_data, {176'b0, 16'h2233, 64'b0});
        @(negedge clk);
        drn_grant = 1'b0;
        chk("R10 done", 256'(drn_done), 256'(1));
        is_head = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; is_head = 1'b0; violate = 1'b0; st_valid = 1'b0; drn_grant = 1'b0;
        st_line = '0; st_word = '0; st_data = '0; st_strb = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_merge_and_drain();
        t_full_and_discard();
        t_discard_then_head();
        t_head_full_miss();
        t_store_to_retiring();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule